// File: doc/BRIEF.md
# Tightly Coupled Quick Memory Controller

This block sits between a processor core and its two caches. It holds a small local word array that both the instruction fetch port and the load/store port can reach. A fixed address window, set at build time by a base and a mask, decides where each request goes. A request whose address falls inside the window always hits and is served from the local array with no wait state, and the matching cache never sees it. A request outside the window passes through unchanged to the instruction or data cache side, and the response comes back from there.

No tags or valid bits are kept: the window compare alone decides hit or miss. The array is either writable RAM, which software loads with word stores before it runs code from it, or a ROM whose contents are fixed at build time and which ignores stores. The array has one access path. When both ports hit the window in the same cycle, the load/store port goes first and the fetch is served one cycle later. Only full 32-bit words are supported in the window. A byte or halfword access that hits the window ends with an error and leaves the array unchanged. Nothing outside the processor ports can reach the array.

Top module: `qmem_ctrl`

## Requirements
- R1: An address hits the window exactly when (addr & MASK) == (BASE & MASK). With the default BASE 0x0000_4000 and MASK 0xFFFF_FF00, 0x4000 through 0x40FC hit, and 0x3FFC, 0x4100, 0xFFFF_4000 and 0x0 miss.
- R2: A fetch that misses the window is passed on combinationally: `ic_req` follows `if_req` and `ic_addr` equals `if_addr`. `if_ack`, `if_rdata` and `if_err` come from the instruction side. A fetch that hits never raises `ic_req`.
- R3: A data access that misses the window is passed on combinationally, with the address, write enable, size and write data unchanged. Its ack, read data and error come from the data side. A data access that hits never raises `dc_req`.
- R4: A word access that hits the window and is not blocked by the other port is acknowledged in the cycle after it is first presented. A read returns the array word indexed by addr[IDXW+1:2], with IDXW = log2(DEPTH).
- R5: In RAM mode, a word store that hits the window (`dt_we`=1, `dt_size`=2) writes the array. The word then reads back through both the data port and the fetch port.
- R6: When both ports present a window hit in the same cycle, the data port is acknowledged one cycle after the request and the fetch port two cycles after.
- R7: A data access that hits the window with a size code of 0 (byte) or 1 (halfword) asserts `dt_err` without `dt_ack` one cycle later, and does not change the array.
- R8: In ROM mode, word i of the array reads (i * 0x0001_0003) XOR 0x5A5A_0000. A word store that hits the window is acknowledged but changes nothing.
- R9: While reset is asserted and in the first cycle after it, `if_ack`, `dt_ack` and `dt_err` are low, provided no downstream response is present.
- R10: Each window hit produces exactly one local response. In the cycle where the ack is given, the same request is still being held, so no second ack follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req | input | 1 | Fetch request, held until acknowledged |
| if_addr | input | AW | Fetch byte address |
| if_ack | output | 1 | Fetch acknowledge |
| if_rdata | output | 32 | Fetch read data |
| if_err | output | 1 | Fetch error (from the instruction side) |
| dt_req | input | 1 | Load/store request, held until ack or error |
| dt_we | input | 1 | 1 = store |
| dt_size | input | 2 | 0 byte, 1 halfword, 2 word |
| dt_addr | input | AW | Load/store byte address |
| dt_wdata | input | 32 | Store data |
| dt_ack | output | 1 | Load/store acknowledge |
| dt_rdata | output | 32 | Load data |
| dt_err | output | 1 | Load/store error |
| ic_req | output | 1 | Forwarded fetch request |
| ic_addr | output | AW | Forwarded fetch address |
| ic_ack | input | 1 | Instruction side acknowledge |
| ic_rdata | input | 32 | Instruction side data |
| ic_err | input | 1 | Instruction side error |
| dc_req | output | 1 | Forwarded data request |
| dc_we | output | 1 | Forwarded store flag |
| dc_size | output | 2 | Forwarded size code |
| dc_addr | output | AW | Forwarded data address |
| dc_wdata | output | 32 | Forwarded store data |
| dc_ack | input | 1 | Data side acknowledge |
| dc_rdata | input | 32 | Data side read data |
| dc_err | input | 1 | Data side error |

## Verification
The assertions take for granted that each master holds its request, address and controls steady until it sees a response, and that the cache sides answer only requests that were forwarded to them and never give ack and error together. The bench keeps to this. Every task raises a request, waits for the response, and drops the request in the response cycle, before the next clock edge. The downstream models answer a forwarded request once, one cycle later.

// File: rtl/qmem_pkg.sv
package qmem_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Preset contents of the read-only variant, computed per word index.
  function automatic logic [31:0] rom_word(input logic [15:0] idx);
    logic [31:0] w;
    w = {16'h0000, idx} * 32'h0001_0003;
    return w ^ 32'h5A5A_0000;
  endfunction

endpackage

// File: rtl/qmem_window.sv
module qmem_window #(
  parameter int          AW   = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] MASK = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] MATCH = BASE & MASK;

  always_comb begin
    hit = ((addr & MASK) == MATCH);
  end
endmodule

// File: rtl/qmem_arb.sv
module qmem_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic if_hit_req,
  input  logic dt_hit_req,
  input  logic dt_word,
  output logic gnt_if,
  output logic gnt_dt,
  output logic if_ack_q,
  output logic dt_ack_q,
  output logic dt_err_q
);
  logic if_elig, dt_elig;
  logic if_ack_d, dt_ack_d, dt_err_d;

  // A port in its response cycle still holds the finished request.
  always_comb begin
    if_elig  = if_hit_req & ~if_ack_q;
    dt_elig  = dt_hit_req & ~dt_ack_q & ~dt_err_q;
    gnt_dt   = dt_elig;
    gnt_if   = if_elig & ~dt_elig;
    if_ack_d = gnt_if;
    dt_ack_d = gnt_dt & dt_word;
    dt_err_d = gnt_dt & ~dt_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_ack_q <= 1'b0;
      dt_ack_q <= 1'b0;
      dt_err_q <= 1'b0;
    end else begin
      if_ack_q <= if_ack_d;
      dt_ack_q <= dt_ack_d;
      dt_err_q <= dt_err_d;
    end
  end
endmodule

// File: rtl/qmem_array.sv
module qmem_array #(
  parameter int DEPTH    = 64,
  parameter bit ROM_MODE = 1'b0,
  localparam int IDXW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            en,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata_q
);
  logic [31:0] rd_d;

  generate
    if (ROM_MODE) begin : g_rom
      logic unused_w;
      always_comb begin
        rd_d     = qmem_pkg::rom_word(16'(idx));
        unused_w = we ^ (^wdata);
      end
    end else begin : g_ram
      logic [31:0] mem [DEPTH];
      always_comb begin
        rd_d = mem[idx];
      end
      always_ff @(posedge clk) begin
        if (en && we) begin
          mem[idx] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (en) begin
      rdata_q <= rd_d;
    end
  end
endmodule

// File: rtl/qmem_ctrl.sv
module qmem_ctrl #(
  parameter int            AW       = 32,
  parameter int            DEPTH    = 64,
  parameter logic [AW-1:0] BASE     = 32'h0000_4000,
  parameter logic [AW-1:0] MASK     = 32'hFFFF_FF00,
  parameter bit            ROM_MODE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  output logic          if_ack,
  output logic [31:0]   if_rdata,
  output logic          if_err,
  input  logic          dt_req,
  input  logic          dt_we,
  input  logic [1:0]    dt_size,
  input  logic [AW-1:0] dt_addr,
  input  logic [31:0]   dt_wdata,
  output logic          dt_ack,
  output logic [31:0]   dt_rdata,
  output logic          dt_err,
  output logic          ic_req,
  output logic [AW-1:0] ic_addr,
  input  logic          ic_ack,
  input  logic [31:0]   ic_rdata,
  input  logic          ic_err,
  output logic          dc_req,
  output logic          dc_we,
  output logic [1:0]    dc_size,
  output logic [AW-1:0] dc_addr,
  output logic [31:0]   dc_wdata,
  input  logic          dc_ack,
  input  logic [31:0]   dc_rdata,
  input  logic          dc_err
);
  localparam int IDXW = $clog2(DEPTH);

  logic if_hit, dt_hit, dt_word;
  logic gnt_if, gnt_dt;
  logic if_lack_q, dt_lack_q, dt_lerr_q;
  logic arr_en, arr_we;
  logic [IDXW-1:0] arr_idx;
  logic [31:0] arr_rd_q;

  qmem_window #(.AW(AW), .BASE(BASE), .MASK(MASK)) u_win_if (
    .addr(if_addr), .hit(if_hit)
  );
  qmem_window #(.AW(AW), .BASE(BASE), .MASK(MASK)) u_win_dt (
    .addr(dt_addr), .hit(dt_hit)
  );

  always_comb begin
    dt_word = (dt_size == qmem_pkg::SZ_WORD);
  end

  qmem_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .if_hit_req(if_req & if_hit),
    .dt_hit_req(dt_req & dt_hit),
    .dt_word   (dt_word),
    .gnt_if    (gnt_if),
    .gnt_dt    (gnt_dt),
    .if_ack_q  (if_lack_q),
    .dt_ack_q  (dt_lack_q),
    .dt_err_q  (dt_lerr_q)
  );

  always_comb begin
    arr_en  = gnt_if | (gnt_dt & dt_word);
    arr_we  = gnt_dt & dt_word & dt_we;
    arr_idx = gnt_dt ? dt_addr[IDXW+1:2] : if_addr[IDXW+1:2];
  end

  qmem_array #(.DEPTH(DEPTH), .ROM_MODE(ROM_MODE)) u_arr (
    .clk    (clk),
    .en     (arr_en),
    .we     (arr_we),
    .idx    (arr_idx),
    .wdata  (dt_wdata),
    .rdata_q(arr_rd_q)
  );

  // Forwarding of window misses and response steering.
  always_comb begin
    ic_req   = if_req & ~if_hit;
    ic_addr  = if_addr;
    if_ack   = if_lack_q | ic_ack;
    if_rdata = if_lack_q ? arr_rd_q : ic_rdata;
    if_err   = ic_err;

    dc_req   = dt_req & ~dt_hit;
    dc_we    = dt_we;
    dc_size  = dt_size;
    dc_addr  = dt_addr;
    dc_wdata = dt_wdata;
    dt_ack   = dt_lack_q | dc_ack;
    dt_rdata = dt_lack_q ? arr_rd_q : dc_rdata;
    dt_err   = dt_lerr_q | dc_err;
  end
endmodule

// File: rtl/qmem_ctrl_chk.sv
module qmem_ctrl_chk #(
  parameter int            AW   = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] MASK = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          if_req,
  input logic [AW-1:0] if_addr,
  input logic          if_ack,
  input logic          ic_req,
  input logic          dt_req,
  input logic [1:0]    dt_size,
  input logic [AW-1:0] dt_addr,
  input logic          dt_ack,
  input logic          dt_err,
  input logic          dc_req
);
  logic if_in, dt_in;
  always_comb begin
    if_in = if_req && ((if_addr & MASK) == (BASE & MASK));
    dt_in = dt_req && ((dt_addr & MASK) == (BASE & MASK));
  end

  a_r2_fetch_hit_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    if_in |-> !ic_req);

  a_r3_data_hit_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    dt_in |-> !dc_req);

  a_r4_fetch_hit_acked_next: assert property (@(posedge clk) disable iff (!rst_n)
    (if_in && !if_ack && !dt_in) |=> if_ack);

  a_r6_data_goes_first: assert property (@(posedge clk) disable iff (!rst_n)
    (if_in && dt_in && !if_ack && !dt_ack && !dt_err) |=> (!if_ack && (dt_ack || dt_err)));

  a_r7_subword_hit_errors: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_in && dt_size != 2'd2 && !dt_ack && !dt_err) |=> (dt_err && !dt_ack));

  a_r10_single_fetch_response: assert property (@(posedge clk) disable iff (!rst_n)
    (if_in && if_ack) |=> !if_ack);

  a_r10_single_data_response: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_in && (dt_ack || dt_err)) |=> !(dt_ack || dt_err));
endmodule

bind qmem_ctrl qmem_ctrl_chk #(.AW(AW), .BASE(BASE), .MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .if_req(if_req), .if_addr(if_addr), .if_ack(if_ack),
  .ic_req(ic_req), .dt_req(dt_req), .dt_size(dt_size), .dt_addr(dt_addr),
  .dt_ack(dt_ack), .dt_err(dt_err), .dc_req(dc_req)
);

// File: tb/sim_qmem_ctrl.sv
`timescale 1ns/1ps
module sim_qmem_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // RAM-mode instance signals
  logic        if_req = 0, dt_req = 0, dt_we = 0;
  logic [31:0] if_addr = 0, dt_addr = 0, dt_wdata = 0;
  logic [1:0]  dt_size = 2;
  logic        if_ack, if_err, dt_ack, dt_err;
  logic [31:0] if_rdata, dt_rdata;
  logic        ic_req, dc_req, dc_we;
  logic [31:0] ic_addr, dc_addr, dc_wdata;
  logic [1:0]  dc_size;
  logic        ic_ack, dc_ack;
  logic [31:0] ic_rdata, dc_rdata;
  logic [1:0]  seen_size;
  logic [31:0] seen_wdata;
  logic        seen_we;

  // ROM-mode instance signals
  logic        r_req = 0, r_we = 0;
  logic [31:0] r_addr = 0, r_wdata = 0;
  logic [1:0]  r_size = 2;
  logic        r_ack, r_err, r_if_ack, r_if_err, r_ic_req, r_dc_req, r_dc_we;
  logic [31:0] r_rdata, r_if_rdata, r_ic_addr, r_dc_addr, r_dc_wdata;
  logic [1:0]  r_dc_size;

  qmem_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_ack(if_ack), .if_rdata(if_rdata), .if_err(if_err),
    .dt_req(dt_req), .dt_we(dt_we), .dt_size(dt_size), .dt_addr(dt_addr), .dt_wdata(dt_wdata),
    .dt_ack(dt_ack), .dt_rdata(dt_rdata), .dt_err(dt_err),
    .ic_req(ic_req), .ic_addr(ic_addr), .ic_ack(ic_ack), .ic_rdata(ic_rdata), .ic_err(1'b0),
    .dc_req(dc_req), .dc_we(dc_we), .dc_size(dc_size), .dc_addr(dc_addr), .dc_wdata(dc_wdata),
    .dc_ack(dc_ack), .dc_rdata(dc_rdata), .dc_err(1'b0)
  );

  qmem_ctrl #(.ROM_MODE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n),
    .if_req(1'b0), .if_addr(32'h0), .if_ack(r_if_ack), .if_rdata(r_if_rdata), .if_err(r_if_err),
    .dt_req(r_req), .dt_we(r_we), .dt_size(r_size), .dt_addr(r_addr), .dt_wdata(r_wdata),
    .dt_ack(r_ack), .dt_rdata(r_rdata), .dt_err(r_err),
    .ic_req(r_ic_req), .ic_addr(r_ic_addr), .ic_ack(1'b0), .ic_rdata(32'h0), .ic_err(1'b0),
    .dc_req(r_dc_req), .dc_we(r_dc_we), .dc_size(r_dc_size), .dc_addr(r_dc_addr), .dc_wdata(r_dc_wdata),
    .dc_ack(1'b0), .dc_rdata(32'h0), .dc_err(1'b0)
  );

  // Downstream models: answer a forwarded request one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_ack <= 1'b0; dc_ack <= 1'b0; ic_rdata <= '0; dc_rdata <= '0;
      seen_size <= '0; seen_wdata <= '0; seen_we <= 1'b0;
    end else begin
      ic_ack   <= ic_req & ~ic_ack;
      ic_rdata <= ~ic_addr;
      dc_ack   <= dc_req & ~dc_ack;
      dc_rdata <= dc_addr ^ 32'h1234_5678;
      if (dc_req) begin
        seen_size <= dc_size; seen_wdata <= dc_wdata; seen_we <= dc_we;
      end
    end
  end

  function automatic logic [31:0] wpat(input int i);
    return (i * 32'h9E37_79B1) + 32'd5;
  endfunction

  function automatic logic [31:0] romv(input int i);
    return (i * 32'h0001_0003) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dreq(input logic we, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, output int lat, output logic [31:0] rd,
                      output logic er, output logic fwd);
    @(negedge clk);
    dt_req = 1; dt_we = we; dt_size = sz; dt_addr = a; dt_wdata = wd;
    #1 fwd = dc_req;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!dt_ack && !dt_err && lat < 20);
    rd = dt_rdata; er = dt_err;
    dt_req = 0;
  endtask

  task automatic freq(input logic [31:0] a, output int lat, output logic [31:0] rd,
                      output logic fwd);
    @(negedge clk);
    if_req = 1; if_addr = a;
    #1 fwd = ic_req;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!if_ack && lat < 20);
    rd = if_rdata;
    if_req = 0;
  endtask

  task automatic rreq(input logic we, input logic [31:0] a, input logic [31:0] wd,
                      output int lat, output logic [31:0] rd);
    @(negedge clk);
    r_req = 1; r_we = we; r_size = 2; r_addr = a; r_wdata = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!r_ack && !r_err && lat < 20);
    rd = r_rdata;
    r_req = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int lat, lat2; logic [31:0] rd; logic er, fwd;
    logic [31:0] miss [4];
    miss[0] = 32'h0000_3FFC; miss[1] = 32'h0000_4100;
    miss[2] = 32'hFFFF_4000; miss[3] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    check("R9 reset if_ack", {31'b0, if_ack}, 0);
    check("R9 reset dt_ack", {31'b0, dt_ack}, 0);
    check("R9 reset dt_err", {31'b0, dt_err}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R9 after reset acks", {29'b0, if_ack, dt_ack, dt_err}, 0);

    // R5/R4/R1: fill the whole window with word stores
    for (int i = 0; i < 64; i++) begin
      dreq(1, 2, 32'h4000 + 4*i, wpat(i), lat, rd, er, fwd);
      check("R4 store latency", lat, 1);
      check("R3 R1 hit store not forwarded", {31'b0, fwd}, 0);
      check("R5 store no error", {31'b0, er}, 0);
    end
    // R5: fetch every word back
    for (int i = 0; i < 64; i++) begin
      freq(32'h4000 + 4*i, lat, rd, fwd);
      check("R4 fetch latency", lat, 1);
      check("R2 R1 hit fetch not forwarded", {31'b0, fwd}, 0);
      check("R5 fetch data", rd, wpat(i));
    end
    for (int i = 0; i < 64; i++) begin
      dreq(0, 2, 32'h4000 + 4*i, 0, lat, rd, er, fwd);
      check("R4 load latency", lat, 1);
      check("R5 load data", rd, wpat(i));
    end

    // R10: response count per request at the ports
    @(negedge clk); if_req = 1; if_addr = 32'h4004;
    @(negedge clk); check("R10 first ack", {31'b0, if_ack}, 1);
    @(negedge clk); check("R10 held request second cycle no ack", {31'b0, if_ack}, 0);
    @(negedge clk); check("R10 next request ack", {31'b0, if_ack}, 1);
    if_req = 0;

    // R7: sub-word hits error and leave the array alone
    dreq(1, 0, 32'h400C, 32'hDEAD_BEEF, lat, rd, er, fwd);
    check("R7 byte store error", {31'b0, er}, 1);
    check("R7 byte store latency", lat, 1);
    dreq(1, 1, 32'h4010, 32'hCAFE_F00D, lat, rd, er, fwd);
    check("R7 half store error", {31'b0, er}, 1);
    dreq(0, 1, 32'h4014, 0, lat, rd, er, fwd);
    check("R7 half load error", {31'b0, er}, 1);
    dreq(0, 2, 32'h400C, 0, lat, rd, er, fwd);
    check("R7 word 3 unchanged", rd, wpat(3));
    dreq(0, 2, 32'h4010, 0, lat, rd, er, fwd);
    check("R7 word 4 unchanged", rd, wpat(4));

    // R2: fetch misses go to the instruction side
    for (int k = 0; k < 4; k++) begin
      freq(miss[k], lat, rd, fwd);
      check("R2 R1 miss fetch forwarded", {31'b0, fwd}, 1);
      check("R2 miss fetch data", rd, ~miss[k]);
    end
    // R3: data misses go to the data side, controls unchanged
    dreq(1, 0, 32'h0000_5001, 32'h0000_00AB, lat, rd, er, fwd);
    check("R3 miss store forwarded", {31'b0, fwd}, 1);
    check("R3 forwarded size", {30'b0, seen_size}, 0);
    check("R3 forwarded wdata", seen_wdata, 32'h0000_00AB);
    check("R3 forwarded we", {31'b0, seen_we}, 1);
    for (int k = 0; k < 4; k++) begin
      dreq(0, 2, miss[k], 0, lat, rd, er, fwd);
      check("R3 R1 miss load forwarded", {31'b0, fwd}, 1);
      check("R3 miss load data", rd, miss[k] ^ 32'h1234_5678);
    end

    // R6: simultaneous hits, data first
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dt_req = 1; dt_we = k[0]; dt_size = 2; dt_addr = 32'h4000 + 16*k; dt_wdata = 32'h7700_0000 + k;
      if_req = 1; if_addr = 32'h4080 + 4*k;
      lat = 0; lat2 = 0;
      for (int c = 1; c <= 4; c++) begin
        @(negedge clk);
        if (dt_req && dt_ack) begin lat = c; dt_req = 0; end
        if (if_req && if_ack) begin lat2 = c; rd = if_rdata; if_req = 0; end
      end
      check("R6 data latency", lat, 1);
      check("R6 fetch latency", lat2, 2);
      check("R6 fetch data", rd, wpat(32 + k));
    end
    dreq(0, 2, 32'h4010, 0, lat, rd, er, fwd);
    check("R6 R5 data store under contention", rd, 32'h7700_0001);

    // R8: ROM contents and ignored stores
    for (int i = 0; i < 64; i++) begin
      rreq(0, 32'h4000 + 4*i, 0, lat, rd);
      check("R8 rom latency", lat, 1);
      check("R8 rom data", rd, romv(i));
    end
    rreq(1, 32'h4014, 32'hFFFF_FFFF, lat, rd);
    check("R8 rom store acked", lat, 1);
    rreq(0, 32'h4014, 0, lat, rd);
    check("R8 rom store no effect", rd, romv(5));

    summary();
    $finish;
  end
endmodule